// File: doc/BRIEF.md
# Transmit Control Register with Graceful Stop

This block is a 32-bit control register for the transmit side of a host Ethernet MAC, accessed over a simple single-cycle CPU read/write bus. Software uses it to turn the transmitter on and to request a graceful stop. A graceful stop lets the frame currently on the wire finish, then halts. The register also issues one-cycle flush strobes for the transmit data FIFO and the transmit status FIFO, and selects whether a full status FIFO holds off new frames.

The transmitter datapath reports three conditions to the register: whether a frame is in progress, whether it has halted, and whether its status FIFO is full. In return it receives an enable level, a pending-stop level, the overrun policy, and a frame-start permission. The FIFOs and the framing logic are separate blocks.

Top module: `tx_ctrl_reg`

## Requirements
- R1: While reset is active and after it releases, tx_enable, stop_req, sts_overrun_ok, flush_data, flush_sts, frame_start_ok and sts_full_irq are all 0, and a read of the register returns 0.
- R2: A read returns the overrun policy in bit 2, the enable in bit 1 and the pending stop in bit 0, with every other bit 0 (including the flush bits 15 and 14). An access is a write when bus_sel and bus_wr are both 1, and a read when bus_sel is 1 and bus_wr is 0. Only byte address 0x070 hits the register. A read at any other address returns 0, and a write at any other address changes nothing.
- R3: A write hitting the register loads bit 2 into sts_overrun_ok and bit 1 into tx_enable, taking effect from the next clock edge.
- R4: Writing 1 to bit 14 makes flush_data high for exactly the one cycle after the write. It is otherwise 0.
- R5: Writing 1 to bit 15 makes flush_sts high for exactly the one cycle after the write. It is otherwise 0.
- R6: While no stop is pending, a write with bit 0 set makes stop_req 1 from the next edge.
- R7: While stop_req is 1, the value written to bit 0 is ignored. Bits 2 and 1 of the same write still take effect.
- R8: A stop completes in a cycle where stop_req, mac_halted are 1 and frame_busy is 0. At the next edge, stop_req and tx_enable both become 0, and this takes priority over a write to bit 1 in the same cycle.
- R9: frame_start_ok is 1 only when tx_enable is 1, stop_req is 0, and it is not the case that sts_full is 1 while sts_overrun_ok is 0.
- R10: sts_full_irq equals sts_full delayed by one clock, whatever the overrun policy.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_sel | input | 1 | Bus access strobe |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | ADDR_W | Byte address |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, combinational |
| frame_busy | input | 1 | Datapath is sending a frame |
| mac_halted | input | 1 | Datapath has stopped |
| sts_full | input | 1 | Transmit status FIFO is full |
| tx_enable | output | 1 | Transmitter enable |
| stop_req | output | 1 | Graceful stop pending |
| sts_overrun_ok | output | 1 | Allow sending with a full status FIFO |
| flush_data | output | 1 | One-cycle data FIFO flush strobe |
| flush_sts | output | 1 | One-cycle status FIFO flush strobe |
| frame_start_ok | output | 1 | A new frame may begin |
| sts_full_irq | output | 1 | Registered status-FIFO-full indication |

## Verification
The assertions assume that the datapath never reports halted while a frame is still in progress. They also assume that bus inputs are stable across each clock edge. The stimulus keeps within these assumptions: it drives mac_halted only on cycles where the bench has frame_busy low, and it changes every input at the falling edge. Random halted pulses are otherwise unconstrained, so stops complete both immediately and after long frames.

// File: rtl/tx_ctrl_pkg.sv
package tx_ctrl_pkg;
  localparam int REG_W    = 32;
  localparam int BIT_FLS  = 15;
  localparam int BIT_FLD  = 14;
  localparam int BIT_OVR  = 2;
  localparam int BIT_EN   = 1;
  localparam int BIT_STOP = 0;
  localparam int N_FLUSH  = 2;

  typedef struct packed {
    logic ovr;
    logic en;
    logic stop;
  } ctl_t;

  function automatic logic [REG_W-1:0] pack_read(input ctl_t s);
    logic [REG_W-1:0] r;
    r           = '0;
    r[BIT_OVR]  = s.ovr;
    r[BIT_EN]   = s.en;
    r[BIT_STOP] = s.stop;
    return r;
  endfunction

  function automatic logic start_allowed(input ctl_t s, input logic full);
    return s.en & ~s.stop & ~(full & ~s.ovr);
  endfunction
endpackage

// File: rtl/tx_ctrl_decode.sv
module tx_ctrl_decode #(
  parameter int ADDR_W = 12,
  parameter logic [ADDR_W-1:0] REG_OFS = 'h70
) (
  input  logic              sel,
  input  logic              wr,
  input  logic [ADDR_W-1:0] addr,
  output logic              wr_hit,
  output logic              rd_hit
);
  logic addr_match;
  always_comb begin
    addr_match = (addr == REG_OFS);
    wr_hit     = sel & wr & addr_match;
    rd_hit     = sel & ~wr & addr_match;
  end
endmodule

// File: rtl/tx_ctrl_state.sv
module tx_ctrl_state
  import tx_ctrl_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic wr_hit,
  input  logic wd_ovr,
  input  logic wd_en,
  input  logic wd_stop,
  input  logic frame_busy,
  input  logic mac_halted,
  output ctl_t state,
  output logic stop_done
);
  ctl_t st_q, st_d;

  always_comb begin
    stop_done = st_q.stop & mac_halted & ~frame_busy;
    st_d = st_q;
    if (wr_hit) begin
      st_d.ovr = wd_ovr;
      st_d.en  = wd_en;
      if (!st_q.stop) st_d.stop = wd_stop;
    end
    if (stop_done) begin
      st_d.stop = 1'b0;
      st_d.en   = 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) st_q <= '0;
    else        st_q <= st_d;
  end

  assign state = st_q;
endmodule

// File: rtl/tx_ctrl_flush.sv
module tx_ctrl_flush #(
  parameter int N = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] req,
  output logic [N-1:0] pulse
);
  for (genvar i = 0; i < N; i++) begin : g_strobe
    logic q;
    always_ff @(posedge clk) begin
      if (!rst_n) q <= 1'b0;
      else        q <= req[i];
    end
    assign pulse[i] = q;
  end
endmodule

// File: rtl/tx_ctrl_reg.sv
module tx_ctrl_reg
  import tx_ctrl_pkg::*;
#(
  parameter int ADDR_W = 12,
  parameter logic [ADDR_W-1:0] REG_OFS = 'h70
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_sel,
  input  logic              bus_wr,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [REG_W-1:0]  bus_wdata,
  output logic [REG_W-1:0]  bus_rdata,
  input  logic              frame_busy,
  input  logic              mac_halted,
  input  logic              sts_full,
  output logic              tx_enable,
  output logic              stop_req,
  output logic              sts_overrun_ok,
  output logic              flush_data,
  output logic              flush_sts,
  output logic              frame_start_ok,
  output logic              sts_full_irq
);
  logic         wr_hit, rd_hit, stop_done;
  ctl_t         state;
  logic [N_FLUSH-1:0] fl_req, fl_pulse;
  logic         irq_q;

  tx_ctrl_decode #(.ADDR_W(ADDR_W), .REG_OFS(REG_OFS)) u_dec (
    .sel(bus_sel), .wr(bus_wr), .addr(bus_addr),
    .wr_hit(wr_hit), .rd_hit(rd_hit)
  );

  tx_ctrl_state u_state (
    .clk(clk), .rst_n(rst_n), .wr_hit(wr_hit),
    .wd_ovr(bus_wdata[BIT_OVR]), .wd_en(bus_wdata[BIT_EN]),
    .wd_stop(bus_wdata[BIT_STOP]),
    .frame_busy(frame_busy), .mac_halted(mac_halted),
    .state(state), .stop_done(stop_done)
  );

  // index 0: data FIFO, index 1: status FIFO
  assign fl_req = {wr_hit & bus_wdata[BIT_FLS], wr_hit & bus_wdata[BIT_FLD]};

  tx_ctrl_flush #(.N(N_FLUSH)) u_flush (
    .clk(clk), .rst_n(rst_n), .req(fl_req), .pulse(fl_pulse)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) irq_q <= 1'b0;
    else        irq_q <= sts_full;
  end

  assign bus_rdata      = rd_hit ? pack_read(state) : '0;
  assign tx_enable      = state.en;
  assign stop_req       = state.stop;
  assign sts_overrun_ok = state.ovr;
  assign flush_data     = fl_pulse[0];
  assign flush_sts      = fl_pulse[1];
  assign frame_start_ok = start_allowed(state, sts_full);
  assign sts_full_irq   = irq_q;
endmodule

// File: rtl/tx_ctrl_reg_chk.sv
module tx_ctrl_reg_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        wr_hit,
  input logic        stop_done,
  input logic [31:0] bus_wdata,
  input logic [31:0] bus_rdata,
  input logic        mac_halted,
  input logic        frame_busy,
  input logic        sts_full,
  input logic        tx_enable,
  input logic        stop_req,
  input logic        sts_overrun_ok,
  input logic        flush_data,
  input logic        flush_sts,
  input logic        frame_start_ok,
  input logic        sts_full_irq
);
  AST_RSVD_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_rdata & 32'hFFFF_FFF8) == 32'h0); // R2
  AST_FLUSH_DATA_SRC: assert property (@(posedge clk) disable iff (!rst_n)
    flush_data |-> $past(wr_hit && bus_wdata[14])); // R4
  AST_FLUSH_STS_SRC: assert property (@(posedge clk) disable iff (!rst_n)
    flush_sts |-> $past(wr_hit && bus_wdata[15])); // R5
  AST_STOP_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    (stop_req && !stop_done) |=> stop_req); // R7
  AST_STOP_CLEARS_EN: assert property (@(posedge clk) disable iff (!rst_n)
    stop_done |=> (!stop_req && !tx_enable)); // R8
  AST_HALT_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    !(mac_halted && frame_busy)); // R8
  AST_START_GATE: assert property (@(posedge clk) disable iff (!rst_n)
    frame_start_ok |-> (tx_enable && !stop_req && !(sts_full && !sts_overrun_ok))); // R9
  AST_IRQ_FOLLOWS: assert property (@(posedge clk) disable iff (!rst_n)
    sts_full |=> sts_full_irq); // R10
endmodule

bind tx_ctrl_reg tx_ctrl_reg_chk u_chk (
  .clk(clk), .rst_n(rst_n), .wr_hit(wr_hit), .stop_done(stop_done),
  .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .mac_halted(mac_halted),
  .frame_busy(frame_busy), .sts_full(sts_full), .tx_enable(tx_enable),
  .stop_req(stop_req), .sts_overrun_ok(sts_overrun_ok),
  .flush_data(flush_data), .flush_sts(flush_sts),
  .frame_start_ok(frame_start_ok), .sts_full_irq(sts_full_irq)
);

// File: tb/tx_ctrl_reg_tb.sv
module tx_ctrl_reg_tb;
  logic        clk = 0;
  logic        rst_n = 0;
  logic        sel = 0, wr = 0;
  logic [11:0] addr = 0;
  logic [31:0] wd = 0;
  logic [31:0] rdata;
  logic        busy = 0, halted = 0, full = 0;
  logic        en, stp, ovr, fd, fs, fok, irq;

  int total = 0, bad = 0;
  logic m_en = 0, m_stop = 0, m_ovr = 0, m_fd = 0, m_fs = 0, m_irq = 0;

  always #2 clk = ~clk;

  tx_ctrl_reg u_dut (
    .clk(clk), .rst_n(rst_n), .bus_sel(sel), .bus_wr(wr), .bus_addr(addr),
    .bus_wdata(wd), .bus_rdata(rdata), .frame_busy(busy), .mac_halted(halted),
    .sts_full(full), .tx_enable(en), .stop_req(stp), .sts_overrun_ok(ovr),
    .flush_data(fd), .flush_sts(fs), .frame_start_ok(fok), .sts_full_irq(irq)
  );

  function automatic logic exp_start(logic e, logic s, logic o, logic f);
    if (!e || s) return 1'b0;
    return o ? 1'b1 : !f;
  endfunction

  function automatic logic [31:0] exp_read(logic s, logic w, logic [11:0] a,
                                           logic o, logic e, logic st);
    if (s && !w && a == 12'h070) return {29'd0, o, e, st};
    return 32'd0;
  endfunction

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s act=%h exp=%h t=%0t", tag, act, exp, $time);
    end
  endtask

  task automatic check_all(string tag);
    chk({tag, " R3 en"}, {31'd0, en}, {31'd0, m_en});
    chk({tag, " R6 stop"}, {31'd0, stp}, {31'd0, m_stop});
    chk({tag, " R3 ovr"}, {31'd0, ovr}, {31'd0, m_ovr});
    chk({tag, " R4 flush_data"}, {31'd0, fd}, {31'd0, m_fd});
    chk({tag, " R5 flush_sts"}, {31'd0, fs}, {31'd0, m_fs});
    chk({tag, " R10 irq"}, {31'd0, irq}, {31'd0, m_irq});
    chk({tag, " R9 start"}, {31'd0, fok}, {31'd0, exp_start(m_en, m_stop, m_ovr, full)});
    chk({tag, " R2 rdata"}, rdata, exp_read(sel, wr, addr, m_ovr, m_en, m_stop));
  endtask

  // one clock: drive at falling edge, update model, check after rising edge
  task automatic step(logic s, logic w, logic [11:0] a, logic [31:0] d,
                      logic b, logic h, logic f, string tag);
    logic hit, done;
    @(negedge clk);
    sel = s; wr = w; addr = a; wd = d; busy = b; halted = h; full = f;
    hit  = s && w && a == 12'h070;
    done = m_stop && h && !b;
    @(posedge clk);
    #1;
    m_fd  = hit && d[14];
    m_fs  = hit && d[15];
    m_irq = f;
    if (hit) begin
      m_ovr = d[2];
      m_en  = d[1];
      if (!m_stop) m_stop = d[0];
    end
    if (done) begin
      m_stop = 1'b0;
      m_en   = 1'b0;
    end
    check_all(tag);
  endtask

  task automatic wreg(logic [31:0] d, string tag);
    step(1, 1, 12'h070, d, 0, 0, 0, tag);
  endtask

  initial begin : watchdog
    #400000;
    bad++; total++;
    $display("FAIL watchdog expired");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin : main
    void'($urandom(32'd20240917));
    repeat (3) @(posedge clk);
    #1;
    check_all("R1 in reset");
    @(negedge clk);
    rst_n = 1;
    step(0, 0, 0, 0, 0, 0, 0, "R1 after reset");
    step(1, 0, 12'h070, 0, 0, 0, 0, "R1 read zero");

    // R2: wrong address write/read ignored
    step(1, 1, 12'h074, 32'hFFFF_FFFF, 0, 0, 0, "R2 bad addr write");
    step(1, 0, 12'h074, 0, 0, 0, 0, "R2 bad addr read");
    // R3/R2: reserved bits read zero
    wreg(32'hFFFF_3FFE, "R3 write all but stop");
    step(1, 0, 12'h070, 0, 0, 0, 0, "R2 readback");
    // R4/R5 flush pulses then drop
    wreg(32'h0000_4006, "R4 flush data");
    step(0, 0, 0, 0, 0, 0, 0, "R4 pulse ends");
    wreg(32'h0000_8006, "R5 flush sts");
    step(0, 0, 0, 0, 0, 0, 0, "R5 pulse ends");
    // R9/R10 hold-off
    wreg(32'h0000_0002, "R3 ovr off");
    step(0, 0, 0, 0, 0, 0, 1, "R9 full holds");
    wreg(32'h0000_0006, "R3 ovr on");
    step(0, 0, 0, 0, 0, 0, 1, "R10 irq with ovr");
    // R6/R7/R8 stop during a frame
    wreg(32'h0000_0003, "R6 stop set");
    step(0, 0, 0, 0, 1, 0, 0, "R8 frame busy");
    step(1, 1, 12'h070, 32'h0000_0002, 1, 0, 0, "R7 write 0 ignored");
    step(1, 0, 12'h070, 0, 1, 0, 0, "R7 readback");
    step(0, 0, 0, 0, 0, 1, 0, "R8 halt");
    step(1, 0, 12'h070, 0, 0, 0, 0, "R8 cleared");
    // R8: idle stop, halt next cycle, with enable write at completion
    wreg(32'h0000_0003, "R6 idle stop");
    step(1, 1, 12'h070, 32'h0000_0006, 0, 1, 0, "R8 priority over enable");
    step(1, 0, 12'h070, 0, 0, 0, 0, "R8 readback");

    // constrained random
    for (int i = 0; i < 3000; i++) begin
      logic s, w, b, h, f;
      logic [11:0] a;
      logic [31:0] d;
      s = ($urandom % 3) != 0;
      w = $urandom % 2;
      a = ($urandom % 5 == 0) ? 12'($urandom) : 12'h070;
      d = $urandom;
      b = ($urandom % 3) == 0;
      h = !b && (($urandom % 4) == 0);
      f = ($urandom % 4) == 0;
      step(s, w, a, d, b, h, f, "rand");
    end

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule